// File: doc/BRIEF.md
# Interrupt-Vector DMA Start Arbiter

This block sits between interrupt sources and the CPU interrupt path. It holds a small set of DMA channels, each with a start-vector register and a transfer counter. Every incoming interrupt vector is compared against the armed channels' start vectors. If it matches, the interrupt becomes a transfer request on one channel and does not reach the CPU. If it does not match, it is forwarded to the CPU unchanged.

Each accepted request lowers the serving channel's counter by one. The request that brings the counter to zero also raises that channel's end interrupt and disarms the channel by clearing its start vector. Software then re-arms the channel, typically while servicing that end interrupt.

When several channels share one vector, the lowest-numbered armed channel takes every request until its count runs out. After that, if the channel is not re-armed, the next higher-numbered channel holding the vector takes over. This is called chaining.

Each channel runs a two-state machine:
- `CH_IDLE` means the channel is unassigned.
- `CH_ARMED` means the channel holds a non-zero vector.

The machine has these transitions:
- ARM: a non-zero vector is written while idle.
- REWRITE: a non-zero vector is written while armed; the channel stays in `CH_ARMED`.
- DISARM: a zero vector is written while armed.
- FINISH: the final grant arrives without a vector write in the same cycle.

Top module: `udma_start_arb`

## Requirements
- R1: After reset every channel is in CH_IDLE, and dma_req, end_irq and cpu_irq_valid are all zero.
- R2: An interrupt whose vector matches no armed channel appears on cpu_irq_valid/cpu_irq_vec one cycle later with the same vector and with dma_req zero. Vector 0 never matches, because a start vector of 0 means unassigned.
- R3: An interrupt whose vector equals an armed channel's start vector produces, one cycle later, dma_req with only that channel's bit set (bit i = channel i), and cpu_irq_valid stays low.
- R4: When several armed channels hold the matching vector, the lowest-numbered one is granted.
- R5: A count write loads the channel's counter with N. Each grant decrements it by one. The N-th grant raises end_irq for that channel for exactly one cycle, in the same cycle as its dma_req bit. A count write in the same cycle as a grant takes precedence over the decrement.
- R6: The grant that ends a channel's count also clears its start vector, so later interrupts with that vector no longer select it.
- R7: After a channel ends and is not re-armed, the next interrupt with the shared vector goes to the next higher-numbered channel holding that vector.
- R8: A vector write to a channel in the same cycle as its final grant takes precedence over the automatic clear, so the channel stays armed with the written vector.
- R9: Writing a start vector of 0 disarms the channel, so its former vector is forwarded to the CPU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_valid | input | 1 | Incoming interrupt strobe |
| irq_vec | input | VEC_W | Incoming interrupt vector code |
| vec_we | input | 1 | Start-vector write strobe |
| cnt_we | input | 1 | Transfer-count write strobe |
| cfg_ch | input | $clog2(NUM_CH) | Channel addressed by a write |
| vec_wdata | input | VEC_W | Start vector to write |
| cnt_wdata | input | CNT_W | Transfer count to write |
| dma_req | output | NUM_CH | One-hot transfer request, one cycle after the interrupt |
| end_irq | output | NUM_CH | Per-channel transfer-end pulse |
| cpu_irq_valid | output | 1 | Forwarded interrupt strobe |
| cpu_irq_vec | output | VEC_W | Forwarded interrupt vector |

## Verification
All results are registered once, so dma_req, end_irq and the CPU pass-through for an interrupt presented before a rising edge are due right after that edge. A write takes effect at that same edge, and so decides the routing of the next interrupt. The bench drives every stimulus on the falling edge and compares all four outputs at the next falling edge, one clock later, against a model of the vector and count registers held in the bench. Many channel configurations with shared vectors are swept, so that priority, expiry and chaining arise repeatedly.

// File: rtl/udma_pkg.sv
package udma_pkg;
    typedef enum logic {
        CH_IDLE  = 1'b0,
        CH_ARMED = 1'b1
    } ch_state_e;
endpackage

// File: rtl/udma_chan.sv
module udma_chan
    import udma_pkg::*;
#(
    parameter int VEC_W = 6,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vec_we,
    input  logic [VEC_W-1:0] vec_wdata,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] in_vec,
    input  logic             grant,
    output logic             hit,
    output logic             last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    ch_state_e        state_q, state_d;
    logic [VEC_W-1:0] vec_q;
    logic [CNT_W-1:0] cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (vec_we && vec_wdata != '0) state_d = CH_ARMED;   // ARM
            end
            CH_ARMED: begin
                if (vec_we) state_d = (vec_wdata == '0) ? CH_IDLE : CH_ARMED; // DISARM / REWRITE
                else if (last) state_d = CH_IDLE;                             // FINISH
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        hit  = in_valid && (state_q == CH_ARMED) && (vec_q == in_vec);
        last = grant && (cnt_q == ONE);
    end

    // vector and counter data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q <= '0;
            cnt_q <= '0;
        end else begin
            if (vec_we)    vec_q <= vec_wdata;
            else if (last) vec_q <= '0;
            if (cnt_we)     cnt_q <= cnt_wdata;
            else if (grant) cnt_q <= cnt_q - ONE;
        end
    end
endmodule

// File: rtl/udma_prio.sv
module udma_prio #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    always_comb begin
        logic taken;
        taken = 1'b0;
        gnt   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !taken) begin
                gnt[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/udma_start_arb.sv
module udma_start_arb #(
    parameter int NUM_CH = 4,
    parameter int VEC_W  = 6,
    parameter int CNT_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      irq_valid,
    input  logic [VEC_W-1:0]          irq_vec,
    input  logic                      vec_we,
    input  logic                      cnt_we,
    input  logic [$clog2(NUM_CH)-1:0] cfg_ch,
    input  logic [VEC_W-1:0]          vec_wdata,
    input  logic [CNT_W-1:0]          cnt_wdata,
    output logic [NUM_CH-1:0]         dma_req,
    output logic [NUM_CH-1:0]         end_irq,
    output logic                      cpu_irq_valid,
    output logic [VEC_W-1:0]          cpu_irq_vec
);
    localparam int CH_W = $clog2(NUM_CH);

    logic [NUM_CH-1:0] hit, gnt, last;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic sel;
        assign sel = (cfg_ch == CH_W'(c));
        udma_chan #(.VEC_W(VEC_W), .CNT_W(CNT_W)) i_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .vec_we    (vec_we && sel),
            .vec_wdata (vec_wdata),
            .cnt_we    (cnt_we && sel),
            .cnt_wdata (cnt_wdata),
            .in_valid  (irq_valid),
            .in_vec    (irq_vec),
            .grant     (gnt[c]),
            .hit       (hit[c]),
            .last      (last[c])
        );
    end

    udma_prio #(.N(NUM_CH)) i_prio (
        .req (hit),
        .gnt (gnt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dma_req       <= '0;
            end_irq       <= '0;
            cpu_irq_valid <= 1'b0;
            cpu_irq_vec   <= '0;
        end else begin
            dma_req       <= gnt;
            end_irq       <= last;
            cpu_irq_valid <= irq_valid && (hit == '0);
            cpu_irq_vec   <= irq_vec;
        end
    end
endmodule

// File: rtl/udma_start_arb_chk.sv
module udma_start_arb_chk #(
    parameter int NUM_CH = 4,
    parameter int VEC_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_valid,
    input logic [VEC_W-1:0]  irq_vec,
    input logic [NUM_CH-1:0] dma_req,
    input logic [NUM_CH-1:0] end_irq,
    input logic              cpu_irq_valid,
    input logic [VEC_W-1:0]  cpu_irq_vec
);
    AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dma_req)); // R4

    AST_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq_valid |-> (dma_req == '0)); // R3

    AST_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(irq_valid) |-> (cpu_irq_valid || dma_req != '0)); // R2

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq_valid || dma_req != '0) |-> $past(irq_valid)); // R3

    AST_PASS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq_valid |-> (cpu_irq_vec == $past(irq_vec))); // R2

    AST_END_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (end_irq & ~dma_req) == '0); // R5
endmodule

bind udma_start_arb udma_start_arb_chk #(.NUM_CH(NUM_CH), .VEC_W(VEC_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_valid     (irq_valid),
    .irq_vec       (irq_vec),
    .dma_req       (dma_req),
    .end_irq       (end_irq),
    .cpu_irq_valid (cpu_irq_valid),
    .cpu_irq_vec   (cpu_irq_vec)
);

// File: tb/test_udma_start_arb.sv
module test_udma_start_arb;
    localparam int NUM_CH = 4;
    localparam int VEC_W  = 6;
    localparam int CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              irq_valid = 1'b0;
    logic [VEC_W-1:0]  irq_vec = '0;
    logic              vec_we = 1'b0;
    logic              cnt_we = 1'b0;
    logic [1:0]        cfg_ch = '0;
    logic [VEC_W-1:0]  vec_wdata = '0;
    logic [CNT_W-1:0]  cnt_wdata = '0;
    logic [NUM_CH-1:0] dma_req, end_irq;
    logic              cpu_irq_valid;
    logic [VEC_W-1:0]  cpu_irq_vec;

    int n_chk = 0;
    int n_bad = 0;
    int m_vec [NUM_CH];
    int m_cnt [NUM_CH];

    always #4 clk = ~clk;

    udma_start_arb #(.NUM_CH(NUM_CH), .VEC_W(VEC_W), .CNT_W(CNT_W)) i_udma_start_arb (
        .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_vec(irq_vec),
        .vec_we(vec_we), .cnt_we(cnt_we), .cfg_ch(cfg_ch), .vec_wdata(vec_wdata),
        .cnt_wdata(cnt_wdata), .dma_req(dma_req), .end_irq(end_irq),
        .cpu_irq_valid(cpu_irq_valid), .cpu_irq_vec(cpu_irq_vec)
    );

    task automatic compare(string req, logic [3:0] e_req, logic [3:0] e_end,
                           logic e_cv, logic [5:0] e_vec);
        n_chk++;
        if (dma_req !== e_req || end_irq !== e_end || cpu_irq_valid !== e_cv ||
            (e_cv && cpu_irq_vec !== e_vec)) begin
            n_bad++;
            $display("FAIL %s: req=%b end=%b cv=%b vec=%0d expected req=%b end=%b cv=%b vec=%0d",
                     req, dma_req, end_irq, cpu_irq_valid, cpu_irq_vec, e_req, e_end, e_cv, e_vec);
        end
    endtask

    task automatic wr_vec(int ch, int v);
        @(negedge clk);
        cfg_ch = 2'(ch); vec_wdata = 6'(v); vec_we = 1'b1;
        @(negedge clk);
        vec_we = 1'b0;
        m_vec[ch] = v;
    endtask

    task automatic wr_cnt(int ch, int n);
        @(negedge clk);
        cfg_ch = 2'(ch); cnt_wdata = 16'(n); cnt_we = 1'b1;
        @(negedge clk);
        cnt_we = 1'b0;
        m_cnt[ch] = n;
    endtask

    // Interrupt, optionally with a same-cycle vector write (R8); check one clock later.
    task automatic fire(int v, bit do_wr, int wch, int wv, string tag);
        int w;
        logic [3:0] e_req, e_end;
        logic e_cv;
        w = -1;
        e_req = '0; e_end = '0; e_cv = 1'b0;
        for (int i = NUM_CH - 1; i >= 0; i--)
            if (m_vec[i] != 0 && m_vec[i] == v) w = i;   // R4 lowest index wins
        if (w >= 0) begin
            e_req[w] = 1'b1;
            if (m_cnt[w] == 1) begin
                e_end[w] = 1'b1;                         // R5
                m_vec[w] = 0;                            // R6 auto clear
            end
            m_cnt[w] = (m_cnt[w] - 1) & 16'hFFFF;
        end else e_cv = 1'b1;
        if (do_wr) m_vec[wch] = wv;                      // R8 write wins
        irq_valid = 1'b1; irq_vec = 6'(v);
        if (do_wr) begin cfg_ch = 2'(wch); vec_wdata = 6'(wv); vec_we = 1'b1; end
        @(negedge clk);
        irq_valid = 1'b0; vec_we = 1'b0;
        compare(tag != "" ? tag : (e_end != 0 ? "R5" : (w >= 0 ? "R3" : "R2")),
                e_req, e_end, e_cv, 6'(v));
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NUM_CH; i++) begin m_vec[i] = 0; m_cnt[i] = 0; end
        repeat (3) @(negedge clk);
        compare("R1", 4'b0, 4'b0, 1'b0, 6'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 / R2: every vector passes through after reset, including 0
        for (int v = 0; v < 64; v++) fire(v, 0, 0, 0, "R2");

        // R4 then R7: channels 1 and 2 share vector 12
        wr_vec(2, 12); wr_cnt(2, 2);
        wr_vec(1, 12); wr_cnt(1, 2);
        fire(12, 0, 0, 0, "R4");
        fire(12, 0, 0, 0, "R5");
        fire(12, 0, 0, 0, "R7");
        fire(12, 0, 0, 0, "R7");
        fire(12, 0, 0, 0, "R6");

        // R8: re-arm in the same cycle as the final grant
        wr_vec(0, 33); wr_cnt(0, 1);
        fire(33, 1, 0, 33, "R8");
        wr_cnt(0, 1);
        fire(33, 0, 0, 0, "R8");
        fire(33, 0, 0, 0, "R6");

        // R9: zero vector disarms
        wr_vec(3, 40); wr_cnt(3, 5);
        fire(40, 0, 0, 0, "R3");
        wr_vec(3, 0);
        fire(40, 0, 0, 0, "R9");

        // Sweep of shared-vector configurations
        for (int p = 0; p < 16; p++) begin
            for (int c = 0; c < NUM_CH; c++) begin
                wr_vec(c, ((p >> c) & 1) ? 5 : 9);
                wr_cnt(c, c + 1 + (p % 3));
            end
            for (int k = 0; k < 8; k++) begin
                fire(5, 0, 0, 0, "");
                fire(9, 0, 0, 0, "");
                fire(k * 7 % 64, 0, 0, 0, "");
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule